// File: doc/BRIEF.md
# Adaptive Subset Replacement Controller

This block makes the eviction decision for a set-associative last-level cache. The ways of every set are split into equal groups (subsets), and only one group per set is active at a time. On a miss the victim is the least-recently-used way inside the active group. Ways in the other groups keep their contents until their group becomes active. Each set counts its own misses. Once that count passes a threshold, the set's active group moves on to the next group, and the count starts again from zero.

The threshold adapts to the running program. Six sampling sets are pinned, two to each of three candidate thresholds (4, 16 and 64). A small monitor counts the misses seen by each pair of sampling sets. Every other set uses the candidate whose sampling sets missed least. The monitor counts saturate and are all halved periodically, so old history fades out.

The cache controller presents one access per cycle: the set index, the way that was touched, and a hit flag. On a miss, the block returns the way to be refilled one cycle later. Tag and data storage, coherence and the fill path sit outside this block.

Top module: `asrp_repl`

## Requirements
- R1: After reset, `victim_valid` is low. Every set has subset 0 active. The recency rank of each way equals its index (rank 0 is most recent), so the first miss to any set returns way 3.
- R2: A returned victim always lies in the set's active subset. Subset s holds ways 4s to 4s+3, so the upper two bits of `victim_way` equal the active subset index.
- R3: The victim is the least-recently-used way of the active subset. A hit on a way (in any subset) or the refill of a victim makes that way most recent. Only the ways that were more recent than it grow one step older.
- R4: Each set counts its misses. When a miss lifts the count above the set's threshold T, that miss still takes its victim from the current subset. The active subset then becomes (s+1) mod 4 and the count clears. Miss T+1 is therefore the switching miss, and miss T+2 takes its victim from the next subset.
- R5: Sets 0 and 1 always use threshold 4. Sets 2 and 3 always use 16. Sets 4 and 5 always use 64. These are candidates 0, 1 and 2.
- R6: All other sets use the threshold of the candidate whose monitor count is lowest. On a tie, the lowest-numbered candidate wins, so right after reset they use 4.
- R7: Each candidate's monitor count is 10 bits wide. It rises by one per miss in that candidate's sampling sets and saturates at 1023. On every 1024th miss since reset (counted over all sets), every monitor count is shifted right by one bit.
- R8: `victim_valid` is high exactly in the cycle after a miss strobe, with `victim_way` valid in that cycle. It is low after a hit or an idle cycle. `acc_way` has no effect on a miss.
- R9: Hits do not add to a set's miss count and do not move its active subset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | One-cycle access strobe |
| acc_set | input | 6 | Set index of the access |
| acc_way | input | 4 | Way that was hit (ignored on a miss) |
| acc_hit | input | 1 | 1 = hit, 0 = miss |
| victim_valid | output | 1 | Victim output valid, one cycle after a miss |
| victim_way | output | 4 | Way chosen for eviction and refill |

## Verification
The assertions assume that `acc_way` names a real way on a hit and that `acc_set` is below the set count. They also take the refill of each victim to happen at the moment it is chosen, so that the same set can be accessed again in the very next cycle.

The stimulus keeps to these assumptions by construction. It strobes at most one access per cycle, uses only in-range sets and ways, and sends hits only as explicit hit strobes. Back-to-back accesses to one set are mixed with idle cycles and accesses to other sets, and then long miss runs drive each kind of threshold across its switching point.

// File: rtl/asrp_pkg.sv
package asrp_pkg;
  // Candidate thresholds grow geometrically: base, base<<step, base<<2*step ...
  function automatic int unsigned cand_threshold(int unsigned base, int unsigned step,
                                                 int unsigned idx);
    return base << (step * idx);
  endfunction
endpackage

// File: rtl/asrp_lru_update.sv
module asrp_lru_update #(
  parameter int WAYS = 16,
  localparam int WW = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][WW-1:0] rank_i,
  input  logic [WW-1:0]           way_i,
  output logic [WAYS-1:0][WW-1:0] rank_o
);
  logic [WW-1:0] pivot;
  assign pivot = rank_i[way_i];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign rank_o[w] = (WW'(w) == way_i) ? '0 :
                       (rank_i[w] < pivot) ? rank_i[w] + 1'b1 : rank_i[w];
  end
endmodule

// File: rtl/asrp_victim_pick.sv
module asrp_victim_pick #(
  parameter int WAYS    = 16,
  parameter int SUBSETS = 4,
  localparam int WW   = $clog2(WAYS),
  localparam int SUBW = $clog2(SUBSETS),
  localparam int WPS  = WAYS / SUBSETS,
  localparam int OW   = $clog2(WPS)
) (
  input  logic [WAYS-1:0][WW-1:0] rank_i,
  input  logic [SUBW-1:0]         subset_i,
  output logic [WW-1:0]           way_o
);
  logic [WW-1:0] best_rank;
  logic [OW-1:0] best_off;

  always_comb begin
    best_off  = '0;
    best_rank = rank_i[{subset_i, OW'(0)}];
    for (int k = 1; k < WPS; k++) begin
      if (rank_i[{subset_i, OW'(k)}] > best_rank) begin
        best_rank = rank_i[{subset_i, OW'(k)}];
        best_off  = OW'(k);
      end
    end
  end

  assign way_o = {subset_i, best_off};
endmodule

// File: rtl/asrp_duel.sv
module asrp_duel #(
  parameter int NCAND = 3,
  parameter int CW    = 10,
  parameter int EW    = 10,
  localparam int CIW  = $clog2(NCAND)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           miss_i,
  input  logic           samp_i,
  input  logic [CIW-1:0] samp_idx_i,
  output logic [CIW-1:0] win_o
);
  logic [CW-1:0] ctr_q [NCAND];
  logic [CW-1:0] ctr_d [NCAND];
  logic [EW-1:0] epoch_q;
  logic          epoch_end;
  logic [CIW-1:0] win;
  logic          win_bad;

  assign epoch_end = miss_i && (&epoch_q);

  always_comb begin
    for (int c = 0; c < NCAND; c++) begin
      ctr_d[c] = ctr_q[c];
      if (samp_i && samp_idx_i == CIW'(c) && ctr_q[c] != '1)
        ctr_d[c] = ctr_q[c] + 1'b1;
      if (epoch_end)
        ctr_d[c] = ctr_d[c] >> 1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      epoch_q <= '0;
      for (int c = 0; c < NCAND; c++) ctr_q[c] <= '0;
    end else if (miss_i) begin
      epoch_q <= epoch_q + 1'b1;
      for (int c = 0; c < NCAND; c++) ctr_q[c] <= ctr_d[c];
    end
  end

  // Lowest count wins; strict compare keeps the lowest index on ties.
  always_comb begin
    win = '0;
    for (int c = 1; c < NCAND; c++)
      if (ctr_q[c] < ctr_q[win]) win = CIW'(c);
  end
  assign win_o = win;

  always_comb begin
    win_bad = 1'b0;
    for (int c = 0; c < NCAND; c++) begin
      if (ctr_q[c] < ctr_q[win_o]) win_bad = 1'b1;
      if (CIW'(c) < win_o && ctr_q[c] == ctr_q[win_o]) win_bad = 1'b1;
    end
  end

  assert_winner_min_R6: assert property (@(posedge clk) disable iff (rst) !win_bad);

  for (genvar c = 0; c < NCAND; c++) begin : g_chk
    assert_duel_sat_R7: assert property (@(posedge clk) disable iff (rst)
      (miss_i && !epoch_end && ctr_q[c] == '1) |=> ctr_q[c] == '1);
    assert_duel_halve_R7: assert property (@(posedge clk) disable iff (rst)
      (miss_i && epoch_end) |=> !ctr_q[c][CW-1]);
  end
endmodule

// File: rtl/asrp_repl.sv
module asrp_repl #(
  parameter int WAYS             = 16,
  parameter int SUBSETS          = 4,
  parameter int SETS             = 64,
  parameter int NCAND            = 3,
  parameter int THR_BASE         = 4,
  parameter int THR_STEP         = 2,
  parameter int SAMPLES_PER_CAND = 2,
  parameter int DUEL_W           = 10,
  parameter int EPOCH_W          = 10,
  localparam int WW      = $clog2(WAYS),
  localparam int SW      = $clog2(SETS),
  localparam int SUBW    = $clog2(SUBSETS),
  localparam int WPS     = WAYS / SUBSETS,
  localparam int CIW     = $clog2(NCAND),
  localparam int NSAMP   = NCAND * SAMPLES_PER_CAND,
  localparam int THR_MAX = THR_BASE << (THR_STEP * (NCAND - 1)),
  localparam int MCW     = $clog2(THR_MAX + 2)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_valid,
  input  logic [SW-1:0] acc_set,
  input  logic [WW-1:0] acc_way,
  input  logic          acc_hit,
  output logic          victim_valid,
  output logic [WW-1:0] victim_way
);
  typedef logic [WAYS-1:0][WW-1:0] rank_vec_t;

  rank_vec_t      rank_q [SETS];
  logic [SUBW-1:0] act_q [SETS];
  logic [MCW-1:0]  mcnt_q [SETS];

  rank_vec_t       init_rank, rd_rank, new_rank;
  logic [SUBW-1:0] rd_act, nxt_act;
  logic [MCW-1:0]  rd_mcnt, mcnt_inc, thr_sel;
  logic [MCW-1:0]  thr_tab [NCAND];
  logic [WW-1:0]   victim, touch_way;
  logic [CIW-1:0]  samp_idx, win_idx, cand_sel;
  logic            is_samp, miss, do_switch;

  for (genvar w = 0; w < WAYS; w++) begin : g_init
    assign init_rank[w] = WW'(w);
  end

  for (genvar c = 0; c < NCAND; c++) begin : g_thr
    assign thr_tab[c] = MCW'(asrp_pkg::cand_threshold(THR_BASE, THR_STEP, c));
  end

  assign rd_rank = rank_q[acc_set];
  assign rd_act  = act_q[acc_set];
  assign rd_mcnt = mcnt_q[acc_set];
  assign miss    = acc_valid && !acc_hit;

  // Set dueling: low sets are pinned to one candidate each
  assign is_samp  = acc_set < SW'(NSAMP);
  assign samp_idx = CIW'(acc_set / SW'(SAMPLES_PER_CAND));
  assign cand_sel = is_samp ? samp_idx : win_idx;
  assign thr_sel  = thr_tab[cand_sel];

  asrp_duel #(.NCAND(NCAND), .CW(DUEL_W), .EW(EPOCH_W)) duel_i (
    .clk(clk), .rst(rst), .miss_i(miss), .samp_i(miss && is_samp),
    .samp_idx_i(samp_idx), .win_o(win_idx)
  );

  asrp_victim_pick #(.WAYS(WAYS), .SUBSETS(SUBSETS)) pick_i (
    .rank_i(rd_rank), .subset_i(rd_act), .way_o(victim)
  );

  assign touch_way = acc_hit ? acc_way : victim;

  asrp_lru_update #(.WAYS(WAYS)) upd_i (
    .rank_i(rd_rank), .way_i(touch_way), .rank_o(new_rank)
  );

  assign mcnt_inc  = rd_mcnt + 1'b1;
  assign do_switch = mcnt_inc > thr_sel;
  assign nxt_act   = (rd_act == SUBW'(SUBSETS - 1)) ? '0 : rd_act + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      victim_valid <= 1'b0;
      victim_way   <= '0;
      for (int s = 0; s < SETS; s++) begin
        rank_q[s] <= init_rank;
        act_q[s]  <= '0;
        mcnt_q[s] <= '0;
      end
    end else begin
      victim_valid <= miss;
      if (miss) victim_way <= victim;
      if (acc_valid) rank_q[acc_set] <= new_rank;
      if (miss) begin
        if (do_switch) begin
          act_q[acc_set]  <= nxt_act;
          mcnt_q[acc_set] <= '0;
        end else begin
          mcnt_q[acc_set] <= mcnt_inc;
        end
      end
    end
  end

  // Independent checks on the chosen victim and the updated ranks
  logic          lru_bad, perm_ok;
  logic [WAYS-1:0] seen;
  always_comb begin
    lru_bad = 1'b0;
    for (int w = 0; w < WAYS; w++)
      if (WW'(w) / WW'(WPS) == WW'(rd_act) && rd_rank[w] > rd_rank[victim]) lru_bad = 1'b1;
  end
  always_comb begin
    seen = '0;
    for (int w = 0; w < WAYS; w++) seen[new_rank[w]] = 1'b1;
    perm_ok = &seen;
  end

  assert_victim_subset_R2: assert property (@(posedge clk) disable iff (rst)
    miss |=> (victim_valid && victim_way[WW-1 -: SUBW] == $past(rd_act)));
  assert_victim_lru_R3: assert property (@(posedge clk) disable iff (rst)
    miss |-> !lru_bad);
  assert_rank_perm_R3: assert property (@(posedge clk) disable iff (rst)
    acc_valid |-> (perm_ok && new_rank[touch_way] == '0));
  assert_mcnt_bound_R4: assert property (@(posedge clk) disable iff (rst)
    acc_valid |-> rd_mcnt <= MCW'(THR_MAX));
  assert_subset_step_R4: assert property (@(posedge clk) disable iff (rst)
    miss |=> (act_q[$past(acc_set)] == $past(rd_act) ||
              act_q[$past(acc_set)] == SUBW'($past(rd_act) + 1'b1)));
  assert_hit_no_victim_R8: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_hit) |=> !victim_valid);
  assert_hit_keeps_R9: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_hit) |=> act_q[$past(acc_set)] == $past(rd_act));
endmodule

// File: tb/asrp_repl_tb.sv
`timescale 1ns/1ps
module asrp_repl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       acc_valid = 1'b0;
  logic [5:0] acc_set = '0;
  logic [3:0] acc_way = '0;
  logic       acc_hit = 1'b0;
  logic       victim_valid;
  logic [3:0] victim_way;

  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  asrp_repl dut_i (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_set(acc_set),
    .acc_way(acc_way), .acc_hit(acc_hit),
    .victim_valid(victim_valid), .victim_way(victim_way)
  );

  typedef struct packed {
    logic [5:0] set;
    logic [3:0] way;
    logic       hit;
    logic       vld;
    logic       ev;
    logic [3:0] ew;
  } vec_t;

  // set, way, hit, strobe, expected valid, expected victim
  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{6'd10, 4'd0,  1'b0, 1'b1, 1'b1, 4'd3},
    '{6'd10, 4'd0,  1'b0, 1'b1, 1'b1, 4'd2},
    '{6'd11, 4'd0,  1'b0, 1'b1, 1'b1, 4'd3},
    '{6'd10, 4'd1,  1'b1, 1'b1, 1'b0, 4'd0},
    '{6'd10, 4'd0,  1'b0, 1'b1, 1'b1, 4'd0},
    '{6'd10, 4'd0,  1'b1, 1'b1, 1'b0, 4'd0},
    '{6'd0,  4'd0,  1'b0, 1'b0, 1'b0, 4'd0},
    '{6'd10, 4'd0,  1'b0, 1'b1, 1'b1, 4'd3},
    '{6'd10, 4'd0,  1'b0, 1'b1, 1'b1, 4'd2},
    '{6'd10, 4'd0,  1'b0, 1'b1, 1'b1, 4'd7},
    '{6'd10, 4'd0,  1'b0, 1'b1, 1'b1, 4'd6},
    '{6'd10, 4'd12, 1'b1, 1'b1, 1'b0, 4'd0},
    '{6'd10, 4'd0,  1'b0, 1'b1, 1'b1, 4'd5},
    '{6'd10, 4'd0,  1'b0, 1'b1, 1'b1, 4'd4}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  task automatic access(input int set, input int way, input bit hit,
                        output bit vv, output int vw);
    acc_valid = 1'b1;
    acc_set   = 6'(set);
    acc_way   = 4'(way);
    acc_hit   = hit;
    @(posedge clk);
    @(negedge clk);
    acc_valid = 1'b0;
    vv = victim_valid;
    vw = int'(victim_way);
  endtask

  task automatic idle(output bit vv, output int vw);
    @(posedge clk);
    @(negedge clk);
    vv = victim_valid;
    vw = int'(victim_way);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    acc_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual 0 expected 1");
      summary();
      $finish;
    end
  end

  initial begin
    bit vv;
    int vw;
    do_reset();
    chk(victim_valid == 1'b0, "R1 valid low after reset", int'(victim_valid), 0);
    access(40, 0, 0, vv, vw);
    chk(vv == 1'b1 && vw == 3, "R1 first victim", vw, 3);
    access(41, 9, 0, vv, vw);
    chk(vw == 3, "R8 acc_way ignored on miss", vw, 3);

    // Vector table: LRU order, subset switch at threshold 4, hits, idle
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].vld) access(int'(VECS[i].set), int'(VECS[i].way), VECS[i].hit, vv, vw);
      else idle(vv, vw);
      chk(vv == VECS[i].ev, "R8 victim_valid timing", int'(vv), int'(VECS[i].ev));
      if (VECS[i].ev) chk(vw == int'(VECS[i].ew), "R3 LRU victim in table", vw, int'(VECS[i].ew));
    end

    // R5: sampling set 0 uses threshold 4
    for (int n = 1; n <= 6; n++) begin
      access(0, 0, 0, vv, vw);
      if (n == 5) chk(vw / 4 == 0, "R5 set0 switching miss in subset 0", vw / 4, 0);
      if (n == 6) chk(vw / 4 == 1, "R5 set0 next subset", vw / 4, 1);
    end

    // R6: cand0=6, cand1=0, cand2=0 -> tie picks candidate 1 (threshold 16)
    for (int n = 1; n <= 18; n++) begin
      access(20, 0, 0, vv, vw);
      if (n == 6)  chk(vw / 4 == 0, "R6 follower not at 4", vw / 4, 0);
      if (n == 17) chk(vw / 4 == 0, "R6 follower switching miss", vw / 4, 0);
      if (n == 18) chk(vw / 4 == 1, "R6 follower threshold 16", vw / 4, 1);
      if (n == 18) chk(vw >= 4 && vw <= 7, "R2 victim within subset 1", vw, 4);
    end

    // R5: sampling set 2 uses threshold 16
    for (int n = 1; n <= 18; n++) begin
      access(2, 0, 0, vv, vw);
      if (n == 17) chk(vw / 4 == 0, "R5 set2 switching miss", vw / 4, 0);
      if (n == 18) chk(vw / 4 == 1, "R5 set2 threshold 16", vw / 4, 1);
    end

    // R6: cand2 now lowest -> followers use 64
    for (int n = 1; n <= 66; n++) begin
      access(30, 0, 0, vv, vw);
      if (n == 17) chk(vw / 4 == 0, "R6 follower not at 16", vw / 4, 0);
      if (n == 65) chk(vw / 4 == 0, "R6 follower switching miss at 64", vw / 4, 0);
      if (n == 66) chk(vw / 4 == 1, "R6 follower threshold 64", vw / 4, 1);
    end

    // R9: hits between misses do not count in sampling set 1 (threshold 4)
    for (int n = 1; n <= 4; n++) access(1, 0, 0, vv, vw);
    for (int n = 0; n < 10; n++) begin
      access(1, 8, 1, vv, vw);
      if (n == 9) chk(vv == 1'b0, "R9 hit gives no victim", int'(vv), 0);
    end
    access(1, 0, 0, vv, vw);
    chk(vw / 4 == 0, "R9 hits not counted", vw / 4, 0);
    access(1, 0, 0, vv, vw);
    chk(vw / 4 == 1, "R9 fifth miss switched", vw / 4, 1);

    // R1: second reset restores state of a touched set
    do_reset();
    chk(victim_valid == 1'b0, "R1 valid low after second reset", int'(victim_valid), 0);
    access(10, 0, 0, vv, vw);
    chk(vw == 3, "R1 ranks restored", vw, 3);

    // R7: cand0=7, cand1=6, cand2=8 -> winner 1; halving gives 3,3,4 -> winner 0
    for (int n = 0; n < 7; n++) access(0, 0, 0, vv, vw);
    for (int n = 0; n < 6; n++) access(2, 0, 0, vv, vw);
    for (int n = 0; n < 8; n++) access(4, 0, 0, vv, vw);
    for (int n = 1; n <= 18; n++) begin
      access(50, 0, 0, vv, vw);
      if (n == 6)  chk(vw / 4 == 0, "R7 before halving not 4", vw / 4, 0);
      if (n == 18) chk(vw / 4 == 1, "R7 before halving threshold 16", vw / 4, 1);
    end
    // 40 misses so far since reset; 984 more makes the 1024th
    for (int n = 0; n < 984; n++) access(8 + (n % 40), 0, 0, vv, vw);
    for (int n = 1; n <= 6; n++) begin
      access(61, 0, 0, vv, vw);
      if (n == 5) chk(vw / 4 == 0, "R7 after halving switching miss", vw / 4, 0);
      if (n == 6) chk(vw / 4 == 1, "R7 after halving threshold 4", vw / 4, 1);
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule